// File: doc/BRIEF.md
# Multi-Page Configuration Image Loader

This block picks one of up to eight configuration images held in a word-addressed memory and sends it to downstream programmable devices. A rising edge on the start input begins a configuration cycle. On that edge the loader captures a 3-bit page number and an output-mode bit. It reads a two-word descriptor for that page from a table at the bottom of the memory, which gives a start address and a length in words. It then fetches the page word by word.

Each word leaves through a valid/ready stream. In serial mode the word goes out one bit per transfer. In parallel mode it goes out one byte per transfer. In both modes the most significant part is sent first. A bad descriptor ends the cycle with an error flag and sends no data. A reconfiguration request drops any cycle in progress, so the system can change the page pins and start again.

The memory port is a plain synchronous read: the data appears on the cycle after the read enable.

Top module: `cfg_page_loader`

## Requirements
- R1: After reset the loader is idle: `busy_o`, `out_valid_o`, `done_o` and `err_o` are all low.
- R2: A cycle starts on a rising edge of `start_i` while the loader is idle. On that edge `page_sel_i` is captured, with bit 2 as the MSB, so value 0 selects page 0. In the next clock the loader reads memory word 2*page, which holds the start address, and then word 2*page+1, which holds the length.
- R3: The loader streams exactly `length` words, starting at the start address and moving to ascending addresses. `out_valid_o` is only high while `busy_o` is high.
- R4: When `par_mode_i` is 0 at the start edge (serial mode), each word is sent as 32 transfers, MSB first. The bit is on `out_data_o[0]` and bits 7:1 are zero.
- R5: When `par_mode_i` is 1 at the start edge (parallel mode), each word is sent as 4 transfers on `out_data_o[7:0]`, starting with bits 31:24.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change.
- R7: `done_o` goes high for exactly one clock, in the cycle after the final transfer is accepted. In that same cycle `busy_o` is low.
- R8: If the length is zero, or start address plus length is greater than MEM_WORDS, the loader raises `err_o`, sends no data and returns to idle. `err_o` stays high until the next start or reconfiguration request.
- R9: Once a cycle is running, changes on `page_sel_i` and `par_mode_i` and further rising edges of `start_i` have no effect on it.
- R10: `reconfig_i` high aborts the cycle. On the next clock the loader is idle with `out_valid_o` and `done_o` low. A later start edge runs a new cycle normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | A rising edge starts a configuration cycle |
| reconfig_i | input | 1 | Abort request; returns the loader to idle |
| page_sel_i | input | PAGE_W | Page number, captured at start |
| par_mode_i | input | 1 | 0 = serial output, 1 = byte output; captured at start |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | AW | Memory word address |
| mem_rd_data_i | input | WORD_W | Read data, valid one clock after the enable |
| out_valid_o | output | 1 | Stream data valid |
| out_data_o | output | BYTE_W | Stream data (serial mode uses bit 0) |
| out_ready_i | input | 1 | Stream ready from the sink |
| busy_o | output | 1 | A configuration cycle is in progress |
| done_o | output | 1 | One-clock pulse after the last accepted transfer |
| err_o | output | 1 | Descriptor rejected |

## Verification
A wrong captured page shows up on the memory address port in the first clock after the start edge, because the descriptor read goes to the wrong word. A wrong word counter or address register shows up as mismatched or missing stream items. It also shows up as a `done_o` pulse that arrives too early, or never arrives. A wrong shift counter or mode latch shows up on the next transfer, as the wrong bit order or the wrong number of transfers per word. A missed abort or a retriggered start shows up as stream traffic that no cycle expects.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_DSC_A,
    LD_DSC_L,
    LD_DSC_CHK,
    LD_FETCH,
    LD_WAIT,
    LD_SHIFT
  } ld_state_e;
endpackage

// File: rtl/cfg_start_latch.sv
module cfg_start_latch #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              idle_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              mode_i,
  output logic              go_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              mode_o
);
  logic              start_q;
  logic [PAGE_W-1:0] page_q;
  logic              mode_q;

  // a start edge only counts in idle and when no abort is pending
  assign go_o = start_i && !start_q && idle_i && !abort_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      page_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      start_q <= start_i;
      if (go_o) begin
        page_q <= page_i;
        mode_q <= mode_i;
      end
    end
  end

  assign page_o = page_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              par_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              last_o
);
  localparam int SER_CNT = WORD_W;
  localparam int PAR_CNT = WORD_W / BYTE_W;
  localparam int CNT_W   = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              par_q;
  logic              accept;

  assign valid_o = (cnt_q != '0);
  assign accept  = valid_o && ready_i;
  assign last_o  = accept && (cnt_q == CNT_W'(1));

  generate
    if (BYTE_W > 1) begin : g_wide
      assign data_o = par_q ? sh_q[WORD_W-1 -: BYTE_W]
                            : {{(BYTE_W-1){1'b0}}, sh_q[WORD_W-1]};
    end else begin : g_narrow
      assign data_o = sh_q[WORD_W-1 -: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= par_i ? CNT_W'(PAR_CNT) : CNT_W'(SER_CNT);
      par_q <= par_i;
    end else if (accept) begin
      sh_q  <= par_q ? (sh_q << BYTE_W) : (sh_q << 1);
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_page_seq.sv
module cfg_page_seq
  import cfg_ldr_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  parameter int AW        = $clog2(MEM_WORDS),
  parameter int WORD_W    = 32,
  parameter int PAGE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              go_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [WORD_W-1:0] rd_data_i,
  input  logic              ser_last_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              ser_load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(MEM_WORDS);

  ld_state_e         state_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] left_q;
  logic [WORD_W-1:0] start_q;
  logic              done_q;
  logic              err_q;
  logic [AW-1:0]     dsc_addr;
  logic              bad_dsc;

  // entry n: start word at 2n, length word at 2n+1
  assign dsc_addr = AW'({page_i, 1'b0});
  assign bad_dsc  = (rd_data_i == '0) ||
                    (({1'b0, start_q} + {1'b0, rd_data_i}) > LIMIT);

  always_comb begin
    rd_en_o   = 1'b0;
    rd_addr_o = addr_q;
    case (state_q)
      LD_DSC_A: begin rd_en_o = 1'b1; rd_addr_o = dsc_addr; end
      LD_DSC_L: begin rd_en_o = 1'b1; rd_addr_o = dsc_addr | AW'(1); end
      LD_FETCH: begin rd_en_o = 1'b1; rd_addr_o = addr_q; end
      default:  ;
    endcase
  end

  assign ser_load_o = (state_q == LD_WAIT);
  assign busy_o     = (state_q != LD_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      start_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (abort_i) begin
      state_q <= LD_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        LD_IDLE: if (go_i) begin
          state_q <= LD_DSC_A;
          err_q   <= 1'b0;
        end
        LD_DSC_A: state_q <= LD_DSC_L;
        LD_DSC_L: begin
          start_q <= rd_data_i;
          state_q <= LD_DSC_CHK;
        end
        LD_DSC_CHK: begin
          if (bad_dsc) begin
            err_q   <= 1'b1;
            state_q <= LD_IDLE;
          end else begin
            left_q  <= rd_data_i;
            addr_q  <= start_q[AW-1:0];
            state_q <= LD_FETCH;
          end
        end
        LD_FETCH: begin
          addr_q  <= addr_q + 1'b1;
          state_q <= LD_WAIT;
        end
        LD_WAIT: begin
          left_q  <= left_q - 1'b1;
          state_q <= LD_SHIFT;
        end
        LD_SHIFT: if (ser_last_i) begin
          if (left_q == '0) begin
            done_q  <= 1'b1;
            state_q <= LD_IDLE;
          end else begin
            state_q <= LD_FETCH;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_page_loader.sv
module cfg_page_loader #(
  parameter int MEM_WORDS = 1024,
  parameter int AW        = $clog2(MEM_WORDS),
  parameter int WORD_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int PAGE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              reconfig_i,
  input  logic [PAGE_W-1:0] page_sel_i,
  input  logic              par_mode_i,
  output logic              mem_rd_en_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [WORD_W-1:0] mem_rd_data_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic              go;
  logic [PAGE_W-1:0] page_q;
  logic              mode_q;
  logic              ser_load;
  logic              ser_last;

  cfg_start_latch #(.PAGE_W(PAGE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .abort_i (reconfig_i),
    .idle_i  (!busy_o),
    .page_i  (page_sel_i),
    .mode_i  (par_mode_i),
    .go_o    (go),
    .page_o  (page_q),
    .mode_o  (mode_q)
  );

  cfg_page_seq #(
    .MEM_WORDS (MEM_WORDS),
    .AW        (AW),
    .WORD_W    (WORD_W),
    .PAGE_W    (PAGE_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .abort_i    (reconfig_i),
    .go_i       (go),
    .page_i     (page_q),
    .rd_data_i  (mem_rd_data_i),
    .ser_last_i (ser_last),
    .rd_en_o    (mem_rd_en_o),
    .rd_addr_o  (mem_addr_o),
    .ser_load_o (ser_load),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  cfg_word_shifter #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clear_i (reconfig_i),
    .load_i  (ser_load),
    .word_i  (mem_rd_data_i),
    .par_i   (mode_q),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .last_o  (ser_last)
  );
endmodule

// File: rtl/cfg_page_loader_chk.sv
module cfg_page_loader_chk #(
  parameter int MEM_WORDS = 1024,
  parameter int AW        = $clog2(MEM_WORDS),
  parameter int BYTE_W    = 8,
  parameter int PAGE_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reconfig_i,
  input logic [PAGE_W-1:0] page_sel_i,
  input logic              mem_rd_en_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              out_valid_o,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  assert_dsc_addr_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (mem_rd_en_o && mem_addr_o == AW'({$past(page_sel_i), 1'b0})));

  assert_valid_in_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> busy_o);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i && !reconfig_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !out_valid_o));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!out_valid_o && !busy_o && !done_o));

  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    reconfig_i |=> (!busy_o && !out_valid_o && !done_o));
endmodule

bind cfg_page_loader cfg_page_loader_chk #(
  .MEM_WORDS (MEM_WORDS),
  .AW        (AW),
  .BYTE_W    (BYTE_W),
  .PAGE_W    (PAGE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reconfig_i  (reconfig_i),
  .page_sel_i  (page_sel_i),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_addr_o  (mem_addr_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/sim_cfg_page_loader.sv
`timescale 1ns/1ps
module sim_cfg_page_loader;
  localparam int MEM_WORDS = 1024;
  localparam int AW        = $clog2(MEM_WORDS);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        reconfig = 1'b0;
  logic [2:0]  page_sel = 3'd0;
  logic        par_mode = 1'b0;
  logic        mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_q = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        busy, done, err;

  logic [31:0] mem [0:MEM_WORDS-1];
  logic [7:0]  exp_q[$];
  int          tests = 0, fails = 0, pops = 0;
  logic        stall_en = 1'b0, hold_low = 1'b0;
  logic [7:0]  lfsr = 8'hA7;
  string       cur_tag = "R3";

  always #4 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_q <= mem[mem_addr];

  cfg_page_loader u0 (
    .clk(clk), .rst(rst), .start_i(start), .reconfig_i(reconfig),
    .page_sel_i(page_sel), .par_mode_i(par_mode),
    .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr), .mem_rd_data_i(mem_q),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // ready driver
  initial forever begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = hold_low ? 1'b0 : (stall_en ? (lfsr[0] | lfsr[2]) : 1'b1);
  end

  // monitor: pops and compares each accepted transfer
  initial forever begin
    @(negedge clk);
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected transfer", int'(out_data), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        pops++;
        check(out_data == e, cur_tag, int'(out_data), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic push_page(input int p, input bit m);
    int s, l;
    s = int'(mem[2*p]);
    l = int'(mem[2*p+1]);
    for (int w = 0; w < l; w++) begin
      logic [31:0] d;
      d = mem[s+w];
      if (m) for (int k = 3; k >= 0; k--) exp_q.push_back(d[8*k +: 8]);
      else   for (int b = 31; b >= 0; b--) exp_q.push_back({7'b0, d[b]});
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); @(posedge clk); #2 start = 1'b0;
  endtask

  // run one cycle; disturb=1 changes pins and retriggers start mid-cycle
  task automatic run_page(input int p, input bit m, input bit bad, input bit disturb);
    int n;
    bit seen_done, seen_err;
    page_sel = 3'(p);
    par_mode = m;
    cur_tag = m ? "R5 byte stream" : "R4 serial stream";
    if (!bad) push_page(p, m);
    pulse_start();
    if (disturb) begin
      repeat (6) @(posedge clk);
      #2 page_sel = ~3'(p); par_mode = ~m; start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    seen_done = 0; seen_err = 0; n = 0;
    while (!seen_done && !seen_err && n < 20000) begin
      @(negedge clk);
      if (done) seen_done = 1;
      if (err)  seen_err = 1;
      n++;
    end
    if (bad) begin
      check(seen_err && !seen_done, "R8 error flag", int'(seen_err), 1);
      repeat (5) @(negedge clk);
      check(err && !busy, "R8 error held", int'(err), 1);
    end else begin
      check(seen_done, "R7 done seen", int'(seen_done), 1);
      check(!busy, "R7 idle with done", int'(busy), 0);
      check(exp_q.size() == 0, "R3 all items before done", exp_q.size(), 0);
      @(negedge clk);
      check(!done, "R7 done one cycle", int'(done), 0);
      repeat (20) @(negedge clk);
      check(!busy && !out_valid, "R9 no retrigger", int'(busy), 0);
    end
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'hA5C30F17;
    mem[0]  = 32;   mem[1]  = 2;
    mem[2]  = 40;   mem[3]  = 1;
    mem[4]  = 48;   mem[5]  = 3;
    mem[6]  = 64;   mem[7]  = 2;
    mem[8]  = 80;   mem[9]  = 0;
    mem[10] = 96;   mem[11] = 3;
    mem[12] = 1020; mem[13] = 10;
    mem[14] = 200;  mem[15] = 4;

    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !done && !err, "R1 reset state", int'(busy), 0);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk);
    check(!busy && !out_valid && !done && !err, "R1 after reset", int'(out_valid), 0);

    run_page(0, 1'b0, 1'b0, 1'b0);             // R2 default page, R4 serial
    stall_en = 1'b1;
    run_page(5, 1'b1, 1'b0, 1'b0);             // R5 byte with stalls (R6)
    run_page(7, 1'b1, 1'b0, 1'b0);             // R2 MSB page bit
    run_page(2, 1'b0, 1'b0, 1'b1);             // R9 pins and start changed mid-cycle
    run_page(3, 1'b1, 1'b0, 1'b1);             // R9 with byte mode
    run_page(4, 1'b0, 1'b1, 1'b0);             // R8 zero length
    run_page(6, 1'b1, 1'b1, 1'b0);             // R8 out of range
    run_page(1, 1'b1, 1'b0, 1'b0);             // error cleared by next start
    check(!err, "R8 error cleared", int'(err), 0);

    // R10 abort in the middle of a page
    page_sel = 3'd7; par_mode = 1'b1; cur_tag = "R10 pre-abort";
    push_page(7, 1'b1);
    pops = 0;
    pulse_start();
    while (pops < 5) @(negedge clk);
    hold_low = 1'b1;
    @(posedge clk); @(posedge clk); #3 reconfig = 1'b1;
    @(posedge clk); #3 reconfig = 1'b0;
    @(negedge clk);
    check(!busy && !out_valid && !done, "R10 abort to idle", int'(busy), 0);
    exp_q.delete();
    repeat (10) @(negedge clk);
    check(!out_valid && !busy, "R10 stays idle", int'(out_valid), 0);
    hold_low = 1'b0;
    stall_en = 1'b0;
    run_page(1, 1'b0, 1'b0, 1'b0);             // R10 recovery
    finish_run();
  end
endmodule